// File: doc/BRIEF.md
# Multi-Stream HDLC Deframer with Configurable Header

This block takes HDLC traffic that arrives one byte per time slot and turns it into tagged payload bytes. Each time slot names a stream. The block keeps a separate deframing context for every stream and restores it whenever that stream's slot comes round. Many streams can therefore share the block, with their slots interleaved in any order. Within a slot the block finds the flag octets, removes the zero bits that the sender inserted after runs of ones, and handles aborts. It then strips a per-stream header of 0, 1 or 2 address bytes and 0 or 1 control byte. If the stream is set up for it, the block also checks a trailing 16-bit frame check sequence.

The address field selects a logical channel, so one stream can carry up to 512 channels. Every payload byte leaves the block with four things attached: its channel number, start-of-frame, end-of-frame and error tags, and a write address into that stream's circular buffer. The buffer size is a power of two. For streams that need more bandwidth, a slot can carry two bytes from a pair of adjacent streams. Both bytes are fed through the even stream's context in one cycle, and up to two payload bytes come out per cycle on two output lanes.

Top module: `hdlc_deframer`

## Requirements
- R1: Frames are delimited by the flag octet 0x7E. Bits of each slot byte are taken LSB first. A 0 that follows five consecutive 1s is removed. The payload bytes are output in the order they were sent, with each byte's first-received bit at bit 0.
- R2: The header is never output. Its length is `cfg_addr_len` address bytes (0, 1 or 2; the value 3 is reserved) plus `cfg_ctrl_len` control bytes (0 or 1).
- R3: The channel number depends on the address length. With a 2-byte address it is bit 0 of the first address byte followed by all 8 bits of the second byte. With a 1-byte address it is that byte, zero-extended. With no address it is 0.
- R4: When `cfg_crc_en` is 1, the CRC is CRC-16 with polynomial x^16+x^12+x^5+1, processed reflected, preset to 0xFFFF and complemented on send. The last two bytes of the frame are withheld from the output. The end-of-frame byte carries err=1 when the residue over the whole frame differs from 0xF0B8. When `cfg_crc_en` is 0, every byte after the header is payload and err stays 0 on a correctly aligned frame.
- R5: The first payload byte of a frame carries sof and the last carries eof. A frame with a single payload byte carries both tags on that byte.
- R6: Seven consecutive 1s inside a frame abort it. If any payload byte has been received, the last received payload byte is output with eof=1 and err=1. Nothing more is output until the next flag.
- R7: A closed frame that has at least one byte but fewer than header + CRC + 1 bytes raises `out_runt` for one cycle and outputs nothing.
- R8: With `slot_paired` set, `slot_byte0` is processed first and then `slot_byte1`, both in the context of `slot_stream`, which must be even.
- R9: Each output byte's write address is a per-stream running count taken modulo 2^`cfg_size_lg` (9 to 15). Lane 1's address follows lane 0's address.
- R10: Contexts of different streams are independent. Interleaving the slots of two streams gives the same output per channel as sending each stream alone.
- R11: After reset no output is valid. Outputs appear one clock after the slot that produces them. There is never output in a cycle after a clock with no slot. Lane 1 is valid only when lane 0 is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | A time-slot byte (or pair) is present |
| slot_stream | input | SW | Stream index of this slot |
| slot_paired | input | 1 | Two bytes from adjacent streams in this slot |
| slot_byte0 | input | 8 | First (even-stream) byte |
| slot_byte1 | input | 8 | Second (odd-stream) byte, used when paired |
| cfg_addr_len | input | 2 | Address field length in bytes for this stream |
| cfg_ctrl_len | input | 1 | Control field length in bytes for this stream |
| cfg_crc_en | input | 1 | Trailing 16-bit CRC present and checked |
| cfg_size_lg | input | 4 | log2 of the circular buffer size, 9 to 15 |
| out_vld | output | 2 | Lane valid bits, lane 0 first |
| out_data | output | 16 | Payload byte per lane |
| out_chan | output | 18 | 9-bit channel number per lane |
| out_sof | output | 2 | Start-of-frame tag per lane |
| out_eof | output | 2 | End-of-frame tag per lane |
| out_err | output | 2 | Frame error tag per lane, valid with eof |
| out_waddr | output | 30 | 15-bit buffer write address per lane |
| out_runt | output | 1 | A runt frame was dropped |

## Verification
A fault in a saved context shows up only when that stream's next slot arrives. Payload bytes then appear shifted or with the wrong bits, channel numbers change in the middle of a frame, or the write address jumps. So interleaved and paired traffic is compared byte by byte per channel. A wrong ones count or wrong stuffing state corrupts the next byte within eight bits and usually breaks the CRC, so it appears as err on that frame's eof. A wrong withholding depth shows at once as a byte count that is off by one or two at the frame's end.

// File: rtl/hdlc_dfr_pkg.sv
package hdlc_dfr_pkg;
  localparam int CHAN_W   = 9;
  localparam int PTR_W    = 15;
  localparam int HOLD_MAX = 3;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_RESID  = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  typedef struct packed {
    logic [1:0] addr_len;
    logic       ctrl_len;
    logic       crc_en;
    logic [3:0] size_lg;
  } cfg_t;

  typedef struct packed {
    logic [2:0]              ones;
    logic                    in_frame;
    logic [7:0]              dbyte;
    logic [2:0]              dcnt;
    logic [1:0]              hidx;
    logic [2:0]              nbytes;
    logic [CHAN_W-1:0]       chan;
    logic [15:0]             crc;
    logic [HOLD_MAX-1:0][7:0] hq;
    logic [1:0]              hcnt;
    logic                    sof_pend;
    logic [PTR_W-1:0]        wptr;
  } ctx_t;

  typedef struct packed {
    logic [7:0]        data;
    logic [CHAN_W-1:0] chan;
    logic              sof;
    logic              eof;
    logic              err;
    logic [PTR_W-1:0]  waddr;
  } emit_t;

  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = crc_in;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ d[k];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ CRC_POLY_R;
    end
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] wrap_ptr(input logic [PTR_W:0] p, input logic [3:0] lg);
    logic [PTR_W:0] m;
    m = ({{PTR_W{1'b0}}, 1'b1} << lg) - 1'b1;
    return PTR_W'(p & m);
  endfunction
endpackage

// File: rtl/hdlc_ctx_store.sv
module hdlc_ctx_store
  import hdlc_dfr_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] idx,
  output ctx_t          rd_ctx,
  input  logic          we,
  input  ctx_t          wr_ctx
);
  ctx_t mem [NUM_STREAMS];

  assign rd_ctx = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_STREAMS; s++) mem[s] <= '0;
    end else if (we) begin
      mem[idx] <= wr_ctx;
    end
  end
endmodule

// File: rtl/hdlc_deframe_core.sv
module hdlc_deframe_core
  import hdlc_dfr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  cfg_t       cfg_i,
  input  logic       paired_i,
  input  logic [7:0] byte0_i,
  input  logic [7:0] byte1_i,
  input  ctx_t       ctx_i,
  output ctx_t       ctx_o,
  output logic [LANES-1:0] lane_vld_o,
  output emit_t      lane_o [LANES],
  output logic       runt_o
);
  localparam int NBITS = 16;

  ctx_t        c;
  emit_t       rec;
  logic        em, got, b;
  logic [7:0]  v;
  logic [15:0] bits;
  logic [2:0]  hdr, minlen;
  logic [1:0]  hdepth;
  logic [1:0]  nemit;

  always_comb begin
    c          = ctx_i;
    runt_o     = 1'b0;
    lane_vld_o = '0;
    for (int l = 0; l < LANES; l++) lane_o[l] = '0;
    nemit  = '0;
    hdr    = {1'b0, cfg_i.addr_len} + {2'b0, cfg_i.ctrl_len};
    hdepth = cfg_i.crc_en ? 2'd3 : 2'd1;
    minlen = hdr + (cfg_i.crc_en ? 3'd3 : 3'd1);
    bits   = {byte1_i, byte0_i};
    em = 1'b0; got = 1'b0; b = 1'b0; v = '0; rec = '0;
    for (int i = 0; i < NBITS; i++) begin
      em = 1'b0; got = 1'b0; v = '0; rec = '0;
      if (i < 8 || paired_i) begin
        b = bits[i];
        if (b) begin
          if (c.ones != 3'd7) c.ones = c.ones + 3'd1;
          if (c.ones == 3'd7) begin
            // abort: close out whatever payload is already pending
            if (c.in_frame && c.hcnt == hdepth) begin
              em = 1'b1;
              rec.data = c.hq[0]; rec.chan = c.chan;
              rec.sof = c.sof_pend; rec.eof = 1'b1; rec.err = 1'b1;
            end
            c.in_frame = 1'b0;
          end else if (c.in_frame) begin
            c.dbyte = {1'b1, c.dbyte[7:1]};
            c.dcnt  = c.dcnt + 3'd1;
            got     = (c.dcnt == 3'd0);
          end
        end else begin
          if (c.ones == 3'd6) begin
            // flag: close a running frame, then open a new one
            if (c.in_frame && c.nbytes != 3'd0) begin
              if (c.nbytes < minlen) runt_o = 1'b1;
              else begin
                em = 1'b1;
                rec.data = c.hq[0]; rec.chan = c.chan;
                rec.sof = c.sof_pend; rec.eof = 1'b1;
                rec.err = (cfg_i.crc_en && c.crc != CRC_RESID) || (c.dcnt != 3'd7);
              end
            end
            c.in_frame = 1'b1; c.dcnt = '0; c.hidx = '0; c.nbytes = '0;
            c.crc = CRC_PRESET; c.hcnt = '0; c.sof_pend = 1'b1; c.chan = '0;
          end else if (c.ones != 3'd5 && c.in_frame) begin
            c.dbyte = {1'b0, c.dbyte[7:1]};
            c.dcnt  = c.dcnt + 3'd1;
            got     = (c.dcnt == 3'd0);
          end
          c.ones = '0;
        end
        if (got) begin
          v     = c.dbyte;
          c.crc = crc16_step(c.crc, v);
          if (c.nbytes != 3'd7) c.nbytes = c.nbytes + 3'd1;
          if ({1'b0, c.hidx} < hdr) begin
            if ({1'b0, c.hidx} < {1'b0, cfg_i.addr_len}) begin
              if (cfg_i.addr_len == 2'd2 && c.hidx == 2'd0) c.chan[8] = v[0];
              else c.chan[7:0] = v;
            end
            c.hidx = c.hidx + 2'd1;
          end else if (c.hcnt == hdepth) begin
            em = 1'b1;
            rec.data = c.hq[0]; rec.chan = c.chan; rec.sof = c.sof_pend;
            c.sof_pend = 1'b0;
            if (hdepth == 2'd3) begin
              c.hq[0] = c.hq[1]; c.hq[1] = c.hq[2]; c.hq[2] = v;
            end else begin
              c.hq[0] = v;
            end
          end else begin
            c.hq[c.hcnt] = v;
            c.hcnt = c.hcnt + 2'd1;
          end
        end
        if (em) begin
          rec.waddr = wrap_ptr({1'b0, c.wptr}, cfg_i.size_lg);
          c.wptr    = wrap_ptr({1'b0, c.wptr} + 1'b1, cfg_i.size_lg);
          if (nemit < 2'(LANES)) begin
            lane_vld_o[nemit] = 1'b1;
            lane_o[nemit]     = rec;
          end
          nemit = nemit + 2'd1;
        end
      end
    end
    ctx_o = c;
  end
endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
  import hdlc_dfr_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int LN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_valid,
  input  logic [SW-1:0]    slot_stream,
  input  logic             slot_paired,
  input  logic [7:0]       slot_byte0,
  input  logic [7:0]       slot_byte1,
  input  logic [1:0]       cfg_addr_len,
  input  logic             cfg_ctrl_len,
  input  logic             cfg_crc_en,
  input  logic [3:0]       cfg_size_lg,
  output logic [LN-1:0]    out_vld,
  output logic [LN*8-1:0]  out_data,
  output logic [LN*CHAN_W-1:0] out_chan,
  output logic [LN-1:0]    out_sof,
  output logic [LN-1:0]    out_eof,
  output logic [LN-1:0]    out_err,
  output logic [LN*PTR_W-1:0] out_waddr,
  output logic             out_runt
);
  cfg_t  cfg;
  ctx_t  ctx_rd, ctx_nx;
  emit_t lane_c [LN];
  emit_t lane_q [LN];
  logic [LN-1:0] vld_c;
  logic  runt_c;
  logic [3:0] size_q;

  assign cfg = '{addr_len: cfg_addr_len, ctrl_len: cfg_ctrl_len,
                 crc_en: cfg_crc_en, size_lg: cfg_size_lg};

  hdlc_ctx_store #(.NUM_STREAMS(NUM_STREAMS)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(slot_stream), .rd_ctx(ctx_rd),
    .we(slot_valid), .wr_ctx(ctx_nx)
  );

  hdlc_deframe_core #(.LANES(LN)) u_core (
    .cfg_i(cfg), .paired_i(slot_paired), .byte0_i(slot_byte0), .byte1_i(slot_byte1),
    .ctx_i(ctx_rd), .ctx_o(ctx_nx), .lane_vld_o(vld_c), .lane_o(lane_c), .runt_o(runt_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_runt <= 1'b0;
      size_q   <= 4'd9;
      for (int l = 0; l < LN; l++) lane_q[l] <= '0;
    end else begin
      out_vld  <= slot_valid ? vld_c : '0;
      out_runt <= slot_valid & runt_c;
      if (slot_valid) begin
        size_q <= cfg_size_lg;
        for (int l = 0; l < LN; l++) lane_q[l] <= lane_c[l];
      end
    end
  end

  for (genvar l = 0; l < LN; l++) begin : g_lane
    assign out_data[l*8 +: 8]          = lane_q[l].data;
    assign out_chan[l*CHAN_W +: CHAN_W] = lane_q[l].chan;
    assign out_sof[l]                  = out_vld[l] & lane_q[l].sof;
    assign out_eof[l]                  = out_vld[l] & lane_q[l].eof;
    assign out_err[l]                  = out_vld[l] & lane_q[l].err;
    assign out_waddr[l*PTR_W +: PTR_W] = lane_q[l].waddr;
  end

  p_lane_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld[1] |-> out_vld[0]);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |=> (out_vld == '0 && !out_runt));
  p_err_on_eof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_err & ~out_eof) == '0);
  p_runt_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_runt |-> out_eof == '0);
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld[1] |-> out_waddr[2*PTR_W-1:PTR_W] ==
                   wrap_ptr({1'b0, out_waddr[PTR_W-1:0]} + 1'b1, size_q));
endmodule

// File: tb/hdlc_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_deframer_tb;
  localparam int NS = 8;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, slot_valid, slot_paired, cfg_ctrl_len, cfg_crc_en;
  logic [2:0] slot_stream;
  logic [7:0] slot_byte0, slot_byte1;
  logic [1:0] cfg_addr_len;
  logic [3:0] cfg_size_lg;
  logic [1:0] out_vld, out_sof, out_eof, out_err;
  logic [15:0] out_data;
  logic [17:0] out_chan;
  logic [29:0] out_waddr;
  logic out_runt;

  hdlc_deframer #(.NUM_STREAMS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_stream(slot_stream),
    .slot_paired(slot_paired), .slot_byte0(slot_byte0), .slot_byte1(slot_byte1),
    .cfg_addr_len(cfg_addr_len), .cfg_ctrl_len(cfg_ctrl_len), .cfg_crc_en(cfg_crc_en),
    .cfg_size_lg(cfg_size_lg), .out_vld(out_vld), .out_data(out_data), .out_chan(out_chan),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err), .out_waddr(out_waddr),
    .out_runt(out_runt)
  );

  typedef struct packed {
    logic [2:0] st; logic pr; logic [1:0] al; logic cl; logic ce; logic [3:0] lg;
    logic [7:0] plen; logic [7:0] seed; logic bad; logic [15:0] addr;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 1'b0, 2'd2, 1'b1, 1'b1, 4'd12, 8'd5,   8'hFF, 1'b0, 16'h01A5},
    '{3'd1, 1'b0, 2'd1, 1'b0, 1'b1, 4'd10, 8'd4,   8'h3C, 1'b0, 16'h0077},
    '{3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd12, 8'd6,   8'hF8, 1'b0, 16'h0000},
    '{3'd1, 1'b0, 2'd1, 1'b1, 1'b1, 4'd10, 8'd3,   8'h7E, 1'b1, 16'h00C2},
    '{3'd2, 1'b1, 2'd2, 1'b0, 1'b1, 4'd11, 8'd9,   8'hFE, 1'b0, 16'hFF5A},
    '{3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 4'd12, 8'd1,   8'h00, 1'b0, 16'h0010},
    '{3'd3, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9,  8'd200, 8'h11, 1'b0, 16'h0000},
    '{3'd3, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9,  8'd200, 8'hEF, 1'b0, 16'h0000},
    '{3'd3, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9,  8'd200, 8'h5D, 1'b1, 16'h0000},
    '{3'd2, 1'b1, 2'd0, 1'b1, 1'b0, 4'd11, 8'd2,   8'hFF, 1'b0, 16'h0000}
  };

  int checks = 0, errors = 0, runt_cnt = 0, bad11 = 0;
  int exp_ptr [NS];
  logic sv_seen = 1'b0;
  logic [34:0] got_q[$];
  logic [34:0] exp_q[$];
  logic [7:0] fb[$];
  bit bitq[$];
  bit bitq2[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) sv_seen <= slot_valid;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((|out_vld || out_runt) && !sv_seen) bad11++;
      if (out_runt) runt_cnt++;
      for (int l = 0; l < 2; l++)
        if (out_vld[l])
          got_q.push_back({out_err[l], out_eof[l], out_sof[l], out_chan[l*9 +: 9],
                           out_data[l*8 +: 8], out_waddr[l*15 +: 15]});
    end
  end

  function automatic logic [15:0] fcs_calc();
    logic [15:0] r = 16'hFFFF;
    foreach (fb[n])
      for (int k = 0; k < 8; k++) begin
        logic mix;
        mix = r[0] ^ fb[n][k];
        r = (r >> 1) ^ (mix ? 16'h8408 : 16'h0000);
      end
    return ~r;
  endfunction

  function automatic logic [7:0] pay(input vec_t v, input int k);
    return v.seed ^ 8'(k * 29);
  endfunction

  task automatic make_bytes(input vec_t v);
    logic [15:0] f;
    fb.delete();
    if (v.al == 2'd2) begin fb.push_back(v.addr[15:8]); fb.push_back(v.addr[7:0]); end
    else if (v.al == 2'd1) fb.push_back(v.addr[7:0]);
    if (v.cl) fb.push_back(8'h03);
    for (int k = 0; k < int'(v.plen); k++) fb.push_back(pay(v, k));
    if (v.ce) begin
      f = fcs_calc();
      if (v.bad) f[0] = ~f[0];
      fb.push_back(f[7:0]); fb.push_back(f[15:8]);
    end
  endtask

  task automatic push_octet_raw(input logic [7:0] o);
    for (int k = 0; k < 8; k++) bitq.push_back(o[k]);
  endtask

  task automatic make_bits(input bit close);
    int ones = 0;
    bitq.delete();
    push_octet_raw(8'h7E);
    foreach (fb[n])
      for (int k = 0; k < 8; k++) begin
        bitq.push_back(fb[n][k]);
        if (fb[n][k]) begin
          ones++;
          if (ones == 5) begin bitq.push_back(1'b0); ones = 0; end
        end else ones = 0;
      end
    if (close) push_octet_raw(8'h7E);
    for (int k = 0; k < 8; k++) bitq.push_back(1'b1);
  endtask

  task automatic expect_frame(input vec_t v, input int nbytes, input bit err_last);
    logic [8:0] ch;
    ch = (v.al == 2'd2) ? v.addr[8:0] : (v.al == 2'd1) ? {1'b0, v.addr[7:0]} : 9'd0;
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back({(k == nbytes-1) & err_last, 1'(k == nbytes-1), 1'(k == 0), ch,
                       pay(v, k), 15'(exp_ptr[v.st] & ((1 << v.lg) - 1))});
      exp_ptr[v.st]++;
    end
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_addr_len = v.al; cfg_ctrl_len = v.cl; cfg_crc_en = v.ce; cfg_size_lg = v.lg;
  endtask

  task automatic send(input logic [2:0] st, input logic pr);
    int w;
    w = pr ? 16 : 8;
    while (bitq.size() % w != 0) bitq.push_back(1'b1);
    for (int i = 0; i < bitq.size(); i += w) begin
      @(negedge clk);
      slot_valid = 1'b1; slot_stream = st; slot_paired = pr;
      for (int k = 0; k < 8; k++) begin
        slot_byte0[k] = bitq[i+k];
        slot_byte1[k] = pr ? bitq[i+8+k] : 1'b0;
      end
    end
    @(negedge clk);
    slot_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    int found;
    chk(got_q.size() == exp_q.size(), {tag, " byte count"}, 64'(got_q.size()), 64'(exp_q.size()));
    foreach (exp_q[e]) begin
      found = -1;
      foreach (got_q[g]) if (found < 0 && got_q[g][31:23] == exp_q[e][31:23]) found = g;
      if (found < 0) chk(1'b0, {tag, " missing byte"}, 64'd0, 64'(exp_q[e]));
      else begin
        chk(got_q[found] == exp_q[e], tag, 64'(got_q[found]), 64'(exp_q[e]));
        got_q.delete(found);
      end
    end
    exp_q.delete(); got_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    vec_t va, vb;
    rst_n = 1'b0; slot_valid = 1'b0; slot_stream = '0; slot_paired = 1'b0;
    slot_byte0 = '0; slot_byte1 = '0;
    cfg_addr_len = '0; cfg_ctrl_len = 1'b0; cfg_crc_en = 1'b0; cfg_size_lg = 4'd12;
    foreach (exp_ptr[s]) exp_ptr[s] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(out_vld == 2'b00, "R11 reset out_vld", 64'(out_vld), 64'd0);
    chk(out_runt == 1'b0, "R11 reset out_runt", 64'(out_runt), 64'd0);

    // table walk: R1 R2 R3 R4 R5 R8 R9
    foreach (VEC[n]) begin
      set_cfg(VEC[n]);
      make_bytes(VEC[n]);
      make_bits(1'b1);
      expect_frame(VEC[n], int'(VEC[n].plen), VEC[n].ce & VEC[n].bad);
      send(VEC[n].st, VEC[n].pr);
      compare($sformatf("R1 R2 R3 R4 R5 R8 R9 row%0d", n));
    end

    // R6 abort after three payload bytes, no CRC
    va = '{3'd4, 1'b0, 2'd1, 1'b0, 1'b0, 4'd12, 8'd3, 8'hA5, 1'b0, 16'h0022};
    set_cfg(va);
    make_bytes(va);
    make_bits(1'b0);
    expect_frame(va, 3, 1'b1);
    send(va.st, 1'b0);
    compare("R6 abort");

    // R7 runt: header plus CRC only
    va = '{3'd5, 1'b0, 2'd1, 1'b0, 1'b1, 4'd12, 8'd0, 8'h00, 1'b0, 16'h0044};
    set_cfg(va);
    make_bytes(va);
    make_bits(1'b1);
    r0 = runt_cnt;
    send(va.st, 1'b0);
    chk(runt_cnt == r0 + 1, "R7 runt pulse", 64'(runt_cnt - r0), 64'd1);
    compare("R7 runt no output");

    // R10 two streams interleaved slot by slot
    va = '{3'd6, 1'b0, 2'd1, 1'b0, 1'b1, 4'd12, 8'd4, 8'hFF, 1'b0, 16'h0031};
    vb = '{3'd7, 1'b0, 2'd1, 1'b0, 1'b1, 4'd12, 8'd5, 8'h3E, 1'b0, 16'h0032};
    set_cfg(va);
    make_bytes(vb); make_bits(1'b1); bitq2 = bitq;
    make_bytes(va); make_bits(1'b1);
    while (bitq.size() < bitq2.size()) bitq.push_back(1'b1);
    while (bitq2.size() < bitq.size()) bitq2.push_back(1'b1);
    while (bitq.size() % 8 != 0) begin bitq.push_back(1'b1); bitq2.push_back(1'b1); end
    expect_frame(va, 4, 1'b0);
    expect_frame(vb, 5, 1'b0);
    for (int i = 0; i < bitq.size(); i += 8) begin
      @(negedge clk);
      slot_valid = 1'b1; slot_paired = 1'b0; slot_stream = 3'd6;
      for (int k = 0; k < 8; k++) slot_byte0[k] = bitq[i+k];
      @(negedge clk);
      slot_stream = 3'd7;
      for (int k = 0; k < 8; k++) slot_byte0[k] = bitq2[i+k];
    end
    @(negedge clk);
    slot_valid = 1'b0;
    repeat (3) @(negedge clk);
    compare("R10 interleave");

    chk(bad11 == 0, "R11 output without slot", 64'(bad11), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule